// File: doc/BRIEF.md
# Capture Buffer Readout Controller

This block drains a circular sample memory once a capture has finished. A rising edge on the trigger-found input, seen while the block is idle, arms a readout. At that edge the block takes a private copy of the window's first and last addresses. It then issues memory read addresses one per cycle, running from the first address towards the last. When it steps past the top location it continues at zero. Each word the memory returns is presented downstream with a valid flag.

The memory is assumed to answer one cycle after an address is issued. A ready input from the downstream consumer gates address issue. Because one read may already be in flight when ready falls, one more valid word can appear in the cycle after ready drops. Between valid words, the output data holds the most recent word. Once the last address has been issued and its word delivered, a single-cycle done pulse closes the readout and the block returns to idle.

Top module: `readout_ctrl`

## Requirements
- R1: A readout starts only on a 0-to-1 transition of `trigFound` sampled while idle. Holding `trigFound` high after a readout ends starts no new readout.
- R2: `startAddr` and `endAddr` are captured at the start edge. Changing them afterwards does not alter the running readout.
- R3: While running with `outReady` high, exactly one read is issued per cycle (`ramRdEn` high), at addresses ascending by one from the captured start address.
- R4: After address 2^ADDR_W-1 the next address issued is 0, so a window whose end is below its start is read through the wrap.
- R5: `outValid` is high in the cycle after each issue, and in that cycle `outData` equals the memory word at the issued address.
- R6: A readout delivers exactly ((end - start) mod 2^ADDR_W) + 1 words, and issuing stops after the end address. When start equals end, exactly one word is delivered.
- R7: `done` is high for exactly one cycle, namely the cycle directly after the last valid word.
- R8: While `outReady` is low, `ramRdEn` stays low. While `outValid` is low, `outData` holds the last delivered word.
- R9: `trigFound` edges that arrive during a readout are ignored. No second readout follows.
- R10: While `rstN` is low, `ramRdEn`, `outValid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigFound | input | 1 | Trigger-found indication from the capture side |
| startAddr | input | ADDR_W | First address of the recorded window |
| endAddr | input | ADDR_W | Last address of the recorded window |
| outReady | input | 1 | Downstream ready; low pauses address issue |
| ramRdData | input | DATA_W | Memory read data, one cycle after the address |
| ramRdAddr | output | ADDR_W | Memory read address |
| ramRdEn | output | 1 | Memory read strobe, one per issued address |
| outData | output | DATA_W | Word forwarded downstream |
| outValid | output | 1 | `outData` carries a fresh word |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
A corrupted address pointer shows up in the very next valid word: the word no longer matches the memory content expected at that position. The same fault also changes the word count, and the late or missing `done` that follows it. A state machine stuck in the running state shows up as a missing `done` within a few cycles of the expected end. A state machine that wrongly re-arms shows up as `ramRdEn` or `outValid` activity in the quiet cycles after `done`. Random stall patterns on `outReady` expose any issue that slips through a stall, and any output word that changes while no valid word is present.

// File: rtl/readout_pkg.sv
package readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_FIN   = 2'd3
  } rdState_t;

  typedef struct packed {
    logic latch;   // capture window bounds, load pointer
    logic issue;   // present one read address this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/readout_datapath.sv
module readout_datapath
  import readout_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic              atEnd,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] endQ;
  logic              validQ;
  logic [DATA_W-1:0] heldData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      endQ    <= '0;
    end else if (strobe.latch) begin
      curAddr <= startAddr;
      endQ    <= endAddr;
    end else if (strobe.issue) begin
      curAddr <= (curAddr == LAST_ADDR) ? '0 : curAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      heldData <= '0;
    end else begin
      validQ <= strobe.issue;
      if (validQ) heldData <= ramRdData;
    end
  end

  assign ramRdAddr = curAddr;
  assign atEnd     = (curAddr == endQ);
  assign outValid  = validQ;
  assign outData   = validQ ? ramRdData : heldData;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outValid) && !outValid) |-> (outData == $past(outData))); // R8

  AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |=> outValid); // R5

endmodule

// File: rtl/readout_control.sv
module readout_control
  import readout_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigFound,
  input  logic         outReady,
  input  logic         atEnd,
  output ctrlStrobes_t strobe,
  output logic         ramRdEn,
  output logic         done
);

  rdState_t state, stateNext;
  logic     trigPrev;
  logic     trigEdge;

  assign trigEdge = trigFound && !trigPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      trigPrev <= 1'b0;
    end else begin
      state    <= stateNext;
      trigPrev <= trigFound;
    end
  end

  always_comb begin
    stateNext    = state;
    strobe       = '0;
    unique case (state)
      ST_IDLE: begin
        if (trigEdge) begin
          strobe.latch = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.issue = outReady;
        if (outReady && atEnd) stateNext = ST_FLUSH;
      end
      ST_FLUSH: stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign ramRdEn = strobe.issue;
  assign done    = (state == ST_FIN);

  AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !ramRdEn); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ramRdEn); // R6

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigFound,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              outReady,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic              ramRdEn,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              done
);

  ctrlStrobes_t strobe;
  logic         atEnd;

  readout_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .trigFound (trigFound),
    .outReady  (outReady),
    .atEnd     (atEnd),
    .strobe    (strobe),
    .ramRdEn   (ramRdEn),
    .done      (done)
  );

  readout_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .endAddr   (endAddr),
    .ramRdData (ramRdData),
    .ramRdAddr (ramRdAddr),
    .atEnd     (atEnd),
    .outData   (outData),
    .outValid  (outValid)
  );

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ramRdEn) && ramRdEn) |-> (ramRdAddr == ADDR_W'($past(ramRdAddr) + 1'b1))); // R3 R4

  AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && !done)); // R10

endmodule

// File: tb/readout_ctrl_bench.sv
module readout_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;

  typedef struct packed {
    logic [3:0]  s;
    logic [3:0]  e;
    logic [15:0] pat;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{s: 4'd2,  e: 4'd9,  pat: 16'hFFFF},
    '{s: 4'd12, e: 4'd3,  pat: 16'hFFFF},
    '{s: 4'd5,  e: 4'd5,  pat: 16'hFFFF},
    '{s: 4'd14, e: 4'd1,  pat: 16'hA5C3},
    '{s: 4'd0,  e: 4'd15, pat: 16'h7777}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          trigFound;
  logic [AW-1:0] startAddr, endAddr;
  logic          outReady;
  logic [DW-1:0] ramRdData;
  logic [AW-1:0] ramRdAddr;
  logic          ramRdEn;
  logic [DW-1:0] outData;
  logic          outValid;
  logic          done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return DW'(int'(a) * 37 + 11);
  endfunction

  always_ff @(posedge clk) if (ramRdEn) ramRdData <= memWord(ramRdAddr);

  readout_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_readout_ctrl (
    .clk(clk), .rstN(rstN), .trigFound(trigFound), .startAddr(startAddr),
    .endAddr(endAddr), .outReady(outReady), .ramRdData(ramRdData),
    .ramRdAddr(ramRdAddr), .ramRdEn(ramRdEn), .outData(outData),
    .outValid(outValid), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic runCase(input int s, input int e, input logic [15:0] pat,
                         input int injectAt, input bit hold);
    int expN;
    int k;
    int lastV;
    bit doneSeen;
    logic [DW-1:0] lastWord;
    expN = ((e - s) & 15) + 1;
    k = 0; lastV = -10; doneSeen = 0; lastWord = '0;
    @(negedge clk);
    startAddr = AW'(s); endAddr = AW'(e); trigFound = 1'b1;
    @(negedge clk);
    if (!hold) trigFound = 1'b0;
    startAddr = AW'(s + 5); endAddr = AW'(e + 3);   // R2: must not matter
    for (int cyc = 0; cyc < 300 && !doneSeen; cyc++) begin
      outReady = pat[cyc % 16];
      if (cyc == injectAt) trigFound = 1'b1;
      else if (!hold) trigFound = 1'b0;
      #1;
      if (!outReady) check(ramRdEn == 1'b0, "R8 no issue while stalled", int'(ramRdEn), 0);
      @(negedge clk);
      if (outValid) begin
        check(outData == memWord(AW'(s + k)), "R5 R3 R4 word content", int'(outData),
              int'(memWord(AW'(s + k))));
        check(k < expN, "R6 no extra word", k + 1, expN);
        lastWord = outData; k++; lastV = cyc;
      end else if (k > 0) begin
        check(outData == lastWord, "R8 data held", int'(outData), int'(lastWord));
      end
      if (done) begin
        doneSeen = 1;
        check(k == expN, "R6 word count", k, expN);
        check(lastV == cyc - 1, "R7 done right after last word", lastV, cyc - 1);
      end
    end
    if (!doneSeen) check(0, "R7 done missing", 0, 1);
    outReady = 1'b1;
    repeat (8) begin
      @(negedge clk);
      check(!outValid && !ramRdEn && !done,
            hold ? "R1 held level starts nothing" : "R9 no second readout",
            int'(outValid) + int'(ramRdEn) + int'(done), 0);
    end
    trigFound = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    rstN = 1'b0; trigFound = 1'b0; startAddr = '0; endAddr = '0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    check(!outValid && !done && !ramRdEn, "R10 reset quiet",
          int'(outValid) + int'(done) + int'(ramRdEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !done && !ramRdEn, "R10 idle after reset",
          int'(outValid) + int'(done) + int'(ramRdEn), 0);

    for (int i = 0; i < NVEC; i++)
      runCase(int'(VEC[i].s), int'(VEC[i].e), VEC[i].pat, -1, 1'b0);

    runCase(0, 7, 16'hFFFF, 3, 1'b0);      // R9 retrigger mid-readout
    runCase(6, 10, 16'hBDEF, -1, 1'b1);    // R1 trigger held high throughout
    runCase(15, 0, 16'hFFFF, -1, 1'b0);    // R4 two-word wrap

    finishRun();
  end

endmodule